// File: doc/BRIEF.md
# Program Counter with Return Stack

This block is the next-address engine of a small processor core. It holds a 21-bit program counter and, every clock, moves it according to a 3-bit sequencing command. The command can step to the next word, hold, take a short or long relative branch, jump to an absolute target, go to one of two fixed interrupt entry addresses, or resume from the most recent return address.

A 16-entry hardware stack of 21-bit return addresses sits beside the counter. A separate 2-bit stack command pushes, pops or leaves the stack alone. A push stores the address of the word after the current one, so a later return resumes behind the call. An instruction decoder drives both commands in the same cycle. A call is therefore "jump + push", a return is "return + pop", and an interrupt entry is "vector + push".

A push onto a full stack or a pop from an empty one raises a sticky fault output, meant to feed the core's reset logic. The fault stays high until reset.

Top module: `pc_retstack`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0, `stack_fault` becomes 0 and the stack becomes empty. All outputs are registered.
- R2: Command 0 (step) makes the next counter value pc+1. Command 5 (hold) keeps the counter unchanged.
- R3: Command 1 (short branch) makes the next value pc+1 plus the 8-bit `br_short` field, read as signed.
- R4: Command 2 (long branch) makes the next value pc+1 plus the 11-bit `br_long` field, read as signed. All counter arithmetic wraps modulo 2^21.
- R5: Command 3 (jump) loads `jump_target`.
- R6: Command 6 loads the high-priority entry address 8. Command 7 loads the low-priority entry address 18.
- R7: Stack command 1 (push) stores pc+1 of the current cycle as the new top entry. Command 4 (return) loads the top entry as it was before this cycle's stack command.
- R8: Stack command 2 (pop) removes the top entry, exposing the one below. Stack command 0 leaves the stack unchanged.
- R9: A push while 16 entries are held sets `stack_fault` and leaves the stack contents unchanged.
- R10: A pop on an empty stack sets `stack_fault` and leaves the stack empty. A return on an empty stack loads 0.
- R11: Once set, `stack_fault` stays high until reset, whatever commands follow.
- R12: Stack command 3 is treated like stack command 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_op | input | 3 | Counter sequencing command (0..7 as in R2-R7) |
| stk_op | input | 2 | Stack command: 0 none, 1 push, 2 pop, 3 none |
| br_short | input | 8 | Signed short branch displacement |
| br_long | input | 11 | Signed long branch displacement |
| jump_target | input | 21 | Absolute jump address |
| pc | output | 21 | Program counter |
| stack_fault | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench aims at the stack edges. It fills all 16 entries and pushes once more: a design that dropped the guard would overwrite a slot or wrap the pointer, and later returns would come back wrong. It pops an empty stack and returns from it: an unguarded pointer would wrap to 15 and hand back a stale address instead of 0. It also runs negative and wrapping displacements at both field widths, which catch a sign extension done from the wrong bit or an offset added to pc instead of pc+1. A long random mix of call, return and reserved-code sequences compares every cycle against a queue model, and would expose a push that stored pc rather than pc+1 or a fault flag that clears itself.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    PC_STEP      = 3'd0,
    PC_BR_SHORT  = 3'd1,
    PC_BR_LONG   = 3'd2,
    PC_JUMP      = 3'd3,
    PC_RETURN    = 3'd4,
    PC_HOLD      = 3'd5,
    PC_VEC_HI    = 3'd6,
    PC_VEC_LO    = 3'd7
  } pc_op_e;

  typedef enum logic [1:0] {
    STK_NONE  = 2'd0,
    STK_PUSH  = 2'd1,
    STK_POP   = 2'd2,
    STK_RSVD  = 2'd3
  } stk_op_e;

endpackage

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int AW     = 21,
  parameter int SW     = 8,
  parameter int LW     = 11,
  parameter int HI_VEC = 8,
  parameter int LO_VEC = 18
) (
  input  logic [AW-1:0] pc_q,
  input  pc_op_e        op,
  input  logic [SW-1:0] off_s,
  input  logic [LW-1:0] off_l,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] tos,
  output logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] pc_inc
);

  localparam logic [AW-1:0] HI_ADDR = AW'(HI_VEC);
  localparam logic [AW-1:0] LO_ADDR = AW'(LO_VEC);

  logic [AW-1:0] sx_s;
  logic [AW-1:0] sx_l;

  assign sx_s   = {{(AW-SW){off_s[SW-1]}}, off_s};
  assign sx_l   = {{(AW-LW){off_l[LW-1]}}, off_l};
  assign pc_inc = pc_q + AW'(1);

  always_comb begin
    unique case (op)
      PC_STEP:     pc_nxt = pc_inc;
      PC_BR_SHORT: pc_nxt = pc_inc + sx_s;
      PC_BR_LONG:  pc_nxt = pc_inc + sx_l;
      PC_JUMP:     pc_nxt = target;
      PC_RETURN:   pc_nxt = tos;
      PC_HOLD:     pc_nxt = pc_q;
      PC_VEC_HI:   pc_nxt = HI_ADDR;
      PC_VEC_LO:   pc_nxt = LO_ADDR;
      default:     pc_nxt = pc_q;
    endcase
  end

endmodule

// File: rtl/pcs_stack_mem.sv
module pcs_stack_mem #(
  parameter int DW    = 21,
  parameter int DEPTH = 16,
  localparam int SA   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SA-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SA-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pcs_stack_ctrl.sv
module pcs_stack_ctrl
  import pcs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int SA   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  output logic          wr_en,
  output logic [SA-1:0] wr_addr,
  output logic [SA-1:0] rd_addr,
  output logic          empty,
  output logic          fault
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;
  logic          full;
  logic          push_req, pop_req;
  logic          push_ok, pop_ok;
  logic          fault_q;

  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);
  assign push_req = (op == STK_PUSH);
  assign pop_req  = (op == STK_POP);
  assign push_ok  = push_req & ~full;
  assign pop_ok   = pop_req & ~empty;
  assign cnt_m1   = cnt_q - CW'(1);

  assign wr_en   = push_ok;
  assign wr_addr = cnt_q[SA-1:0];
  assign rd_addr = cnt_m1[SA-1:0];
  assign fault   = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (push_ok)     cnt_q <= cnt_q + CW'(1);
      else if (pop_ok) cnt_q <= cnt_m1;
      if ((push_req & full) | (pop_req & empty)) fault_q <= 1'b1;
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  assert_overflow_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> (fault_q && cnt_q == FULL_CNT));

  assert_underflow_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> (fault_q && cnt_q == '0));

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q);

  assert_idle_keeps_depth_R12: assert property (@(posedge clk) disable iff (rst)
    (op == STK_NONE || op == STK_RSVD) |=> $stable(cnt_q));

endmodule

// File: rtl/pc_retstack.sv
module pc_retstack
  import pcs_pkg::*;
#(
  parameter int AW      = 21,
  parameter int SW      = 8,
  parameter int LW      = 11,
  parameter int DEPTH   = 16,
  parameter int HI_VEC  = 8,
  parameter int LO_VEC  = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    pc_op,
  input  logic [1:0]    stk_op,
  input  logic [SW-1:0] br_short,
  input  logic [LW-1:0] br_long,
  input  logic [AW-1:0] jump_target,
  output logic [AW-1:0] pc,
  output logic          stack_fault
);

  localparam int SA = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pc_op_e        op_c;
  stk_op_e       sop_c;
  logic [AW-1:0] pc_q, pc_nxt, pc_inc, tos, rd_data;
  logic          wr_en, empty;
  logic [SA-1:0] wr_addr, rd_addr;

  assign op_c  = pc_op_e'(pc_op);
  assign sop_c = stk_op_e'(stk_op);
  assign tos   = empty ? '0 : rd_data;

  pcs_next_addr #(
    .AW(AW), .SW(SW), .LW(LW), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
  ) u_next (
    .pc_q   (pc_q),
    .op     (op_c),
    .off_s  (br_short),
    .off_l  (br_long),
    .target (jump_target),
    .tos    (tos),
    .pc_nxt (pc_nxt),
    .pc_inc (pc_inc)
  );

  pcs_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .op      (sop_c),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .empty   (empty),
    .fault   (stack_fault)
  );

  pcs_stack_mem #(.DW(AW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (pc_inc),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc = pc_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (op_c == PC_STEP) |=> (pc_q == $past(pc_q) + AW'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (op_c == PC_HOLD) |=> $stable(pc_q));

  assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
    (op_c == PC_JUMP) |=> (pc_q == $past(jump_target)));

  assert_vec_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (op_c == PC_VEC_HI) |=> (pc_q == AW'(HI_VEC)));

  assert_vec_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (op_c == PC_VEC_LO) |=> (pc_q == AW'(LO_VEC)));

  assert_ret_after_push_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en ##1 (op_c == PC_RETURN)) |=> (pc_q == $past(pc_q, 2) + AW'(1)));

  assert_empty_return_R10: assert property (@(posedge clk) disable iff (rst)
    (empty && op_c == PC_RETURN) |=> (pc_q == '0));

endmodule

// File: tb/pc_retstack_tb.sv
module pc_retstack_tb;

  localparam int  AW   = 21;
  localparam int  DEP  = 16;
  localparam int  MASK = (1 << AW) - 1;
  localparam longint WD_NS = 64'd1_500_000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    pc_op = 3'd0;
  logic [1:0]    stk_op = 2'd0;
  logic [7:0]    br_short = '0;
  logic [10:0]   br_long = '0;
  logic [AW-1:0] jump_target = '0;
  logic [AW-1:0] pc;
  logic          stack_fault;

  int checks = 0;
  int failures = 0;

  int m_pc = 0;
  bit m_fault = 1'b0;
  int m_stk[$];

  always #4 clk = ~clk;

  pc_retstack u_dut (
    .clk(clk), .rst(rst), .pc_op(pc_op), .stk_op(stk_op),
    .br_short(br_short), .br_long(br_long), .jump_target(jump_target),
    .pc(pc), .stack_fault(stack_fault)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string pc_tag(input int op);
    case (op)
      0, 5: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      default: return "R6";
    endcase
  endfunction

  // drive one cycle after a falling edge, update the model, check at the next falling edge
  task automatic cyc(input int op, input int sop, input int o8, input int o11,
                     input int tgt, input string tag);
    int tos, inc, nxt;
    string ptag, ftag;
    pc_op = op[2:0]; stk_op = sop[1:0];
    br_short = o8[7:0]; br_long = o11[10:0]; jump_target = tgt[AW-1:0];
    tos = (m_stk.size() == 0) ? 0 : m_stk[$];
    inc = (m_pc + 1) & MASK;
    case (op)
      0: nxt = inc;
      1: nxt = (inc + int'($signed(o8[7:0]))) & MASK;
      2: nxt = (inc + int'($signed(o11[10:0]))) & MASK;
      3: nxt = tgt & MASK;
      4: nxt = tos;
      5: nxt = m_pc;
      6: nxt = 8;
      default: nxt = 18;
    endcase
    ftag = "R11";
    if (sop == 1) begin
      if (m_stk.size() == DEP) begin m_fault = 1'b1; ftag = "R9"; end
      else m_stk.push_back(inc);
    end else if (sop == 2) begin
      if (m_stk.size() == 0) begin m_fault = 1'b1; ftag = "R10"; end
      else void'(m_stk.pop_back());
    end else if (sop == 3) ftag = "R12";
    m_pc = nxt;
    ptag = (tag != "") ? tag : pc_tag(op);
    @(negedge clk);
    check(ptag, int'(pc), m_pc);
    check(ftag, int'(stack_fault), int'(m_fault));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pc_op = 3'd3; jump_target = 21'h1ABCD; stk_op = 2'd1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_fault = 1'b0; m_stk.delete();
    check("R1", int'(pc), 0);
    check("R1", int'(stack_fault), 0);
  endtask

  task automatic run_all();
    int v;
    do_reset();
    // R1: empty stack after reset, return yields 0 (R10 empty-return rule)
    cyc(3, 0, 0, 0, 21'h00500, "R5");
    cyc(4, 0, 0, 0, 0, "R1");
    // R2 step / hold
    cyc(0, 0, 0, 0, 0, "R2");
    cyc(5, 0, 0, 0, 0, "R2");
    cyc(5, 3, 0, 0, 0, "R2");
    // R3 short branches both signs
    cyc(1, 0, 8'h7F, 0, 0, "R3");
    cyc(1, 0, 8'h80, 0, 0, "R3");
    cyc(1, 0, 8'hFF, 0, 0, "R3");
    // R4 long branches and wrap at both ends
    cyc(2, 0, 0, 11'h3FF, 0, "R4");
    cyc(2, 0, 0, 11'h400, 0, "R4");
    cyc(3, 0, 0, 0, 21'h1FFFFC, "R5");
    cyc(2, 0, 0, 11'h005, 0, "R4");
    cyc(3, 0, 0, 0, 21'h000003, "R5");
    cyc(2, 0, 0, 11'h7F0, 0, "R4");
    cyc(1, 0, 8'hF0, 0, 0, "R4");
    // R6 vectors, pushing the interrupted address
    cyc(6, 1, 0, 0, 0, "R6");
    cyc(7, 1, 0, 0, 0, "R6");
    // R7 return to the most recent push, LIFO
    cyc(4, 2, 0, 0, 0, "R7");
    cyc(4, 2, 0, 0, 0, "R7");
    // R8: pop exposes the lower entry
    cyc(3, 1, 0, 0, 21'h00100, "R8");
    cyc(3, 1, 0, 0, 21'h00200, "R8");
    cyc(0, 2, 0, 0, 0, "R8");
    cyc(4, 0, 0, 0, 0, "R8");
    cyc(4, 2, 0, 0, 0, "R8");
    // R12 reserved stack code leaves the stack alone
    cyc(3, 1, 0, 0, 21'h00777, "R12");
    cyc(0, 3, 0, 0, 0, "R12");
    cyc(0, 3, 0, 0, 0, "R12");
    cyc(4, 2, 0, 0, 0, "R12");
    // R9 fill then overflow; contents must survive
    for (int i = 0; i < DEP; i++) cyc(3, 1, 0, 0, 21'h1000 + i * 16, "R9");
    check("R9", int'(stack_fault), 0);
    cyc(3, 1, 0, 0, 21'h0F000, "R9");
    for (int i = 0; i < DEP; i++) cyc(4, 2, 0, 0, 0, "R9");
    // R10 underflow and empty return
    cyc(4, 2, 0, 0, 0, "R10");
    cyc(4, 0, 0, 0, 0, "R10");
    // R11 sticky across further benign traffic
    cyc(3, 1, 0, 0, 21'h00040, "R11");
    cyc(4, 2, 0, 0, 0, "R11");
    check("R11", int'(stack_fault), 1);
    do_reset();
    check("R1", int'(stack_fault), 0);
    // underflow fault source on its own
    cyc(0, 2, 0, 0, 0, "R10");
    do_reset();
    // random mixed traffic
    for (int i = 0; i < 4000; i++) begin
      v = int'($urandom_range(0, 7));
      cyc(v, int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 2047)), int'($urandom_range(0, MASK)), "");
      if ((i % 900) == 899) do_reset();
    end
  endtask

  initial begin
    @(negedge clk);
    fork
      run_all();
      begin
        #(WD_NS);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule